// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who owns a processor's external memory bus. An outside master asks for the bus by pulling an active-low hold request. The arbiter answers with an active-low hold acknowledge. It releases the bus only when no external cycle is in flight. A grant moves through fixed steps. First the output enables for the address, data, write enable, read, read/write and zone-select strobes are dropped, so that those pins float. One clock later the acknowledge goes low. Handing the bus back runs the same steps in reverse: the acknowledge rises first, and pin drive returns one clock later. The request pin is asynchronous and passes through a two-stage synchronizer before the arbiter acts on it.

A software-writable refusal bit is cleared by reset. Setting it takes back a grant that is in progress as soon as the bus is idle, and new requests are refused while it stays set. If the request is already low during system reset, the arbiter leaves reset with the bus floated and the acknowledge already low. While the bus is given away, the processor keeps running from internal memory. Any access it tries on the external interface raises a stall. The stall drops in the same cycle that pin drive comes back, and that is the first cycle in which the access can proceed. A narrow-bus input limits data pin drive to the low half of the data bus.

Top module: `bus_hold_ctrl`

## Requirements
- R1: System reset clears the refusal bit. A request made after a reset that follows a write of 1 to that bit is granted with the normal timing. With the request high during reset, the outputs leave reset with all enables at 1 and hold_ack_n at 1.
- R2: If hold_req_n is low during reset, then from the first cycle after reset every enable output is 0 and hold_ack_n is 0.
- R3: With ext_busy low and the refusal bit clear, the enables stay at 1 for the first two rising edges after hold_req_n falls and drop to 0 on the third. hold_ack_n falls on the fourth edge.
- R4: A request is never granted while ext_busy is 1. The enables drop on the first edge at which ext_busy has been sampled 0 and the synchronized request is active.
- R5: While granted, once hold_req_n rises, hold_ack_n returns to 1 on the third rising edge. The enables return to 1 on the fourth edge.
- R6: A write of 1 to the refusal bit (mode_wr_en=1, mode_wr_val=1) during a grant sets hold_ack_n to 1 on the edge after the write, provided ext_busy is 0 at that edge. The enables return to 1 one edge later. While ext_busy stays 1, the grant is held.
- R7: While the refusal bit is 1, an active request has no effect: the enables stay at 1 and hold_ack_n stays at 1. When the bit is cleared with the request still low, the enables drop on the edge after the clearing write, and hold_ack_n falls on the next edge.
- R8: ext_stall is 1 exactly when cpu_ext_req is 1 and the enables are 0. It falls in the same cycle in which the enables return to 1.
- R9: All enables switch together (addr_oe, rd_oe, rw_oe, every we_oe and zcs_oe bit, and the low half of data_oe). With narrow_mode=1, data_oe bits 31:16 are always 0. With narrow_mode=0, they follow the other enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| hold_req_n | input | 1 | Asynchronous active-low hold request from the outside master |
| mode_wr_en | input | 1 | Write strobe for the refusal bit |
| mode_wr_val | input | 1 | Value written to the refusal bit (1 = refuse or revoke hold) |
| ext_busy | input | 1 | An external bus cycle is in progress |
| cpu_ext_req | input | 1 | The CPU is attempting an external interface access |
| narrow_mode | input | 1 | 1 = 16-bit data bus, 0 = 32-bit data bus |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| addr_oe | output | 1 | Address bus drive enable |
| data_oe | output | 32 | Per-bit data bus drive enables |
| we_oe | output | 2 | Write enable strobe drive enables |
| rd_oe | output | 1 | Read strobe drive enable |
| rw_oe | output | 1 | Read/write line drive enable |
| zcs_oe | output | 3 | Zone-select strobe drive enables |
| ext_stall | output | 1 | Stall for the pending CPU external access |

## Verification
A sequencer stuck in one of its two transition states shows at the ports within one clock. The enables are then low while hold_ack_n is high, and that pair must last exactly one cycle on each grant and each release. A sequencer that stepped through the wrong order shows up on the edge where hold_ack_n changes, because the enables must already be low when the acknowledge falls and still low when it rises. A refusal bit that failed to set or clear shows two edges after the write, as a grant that was not taken back or a request that was not granted. A wrong synchronizer depth moves every grant and release edge by one cycle, and the timing checks measure those edges to the cycle.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    // Sequencer states: bus owned by the CPU, enables dropped, granted, returning
    typedef enum logic [1:0] {
        ST_OWN   = 2'd0,
        ST_REL   = 2'd1,
        ST_GRANT = 2'd2,
        ST_RET   = 2'd3
    } hold_st_e;

    typedef struct packed {
        logic drive;   // pins driven by this side
        logic ack_n;   // acknowledge level
    } bus_ctl_t;

    function automatic bus_ctl_t ctl_of(hold_st_e s);
        bus_ctl_t c;
        case (s)
            ST_OWN:   begin c.drive = 1'b1; c.ack_n = 1'b1; end
            ST_REL:   begin c.drive = 1'b0; c.ack_n = 1'b1; end
            ST_GRANT: begin c.drive = 1'b0; c.ack_n = 1'b0; end
            default:  begin c.drive = 1'b0; c.ack_n = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // During reset the chain is preloaded with the live pin level
    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{d}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
    import bhc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_req_n,
    input  logic     req_act,
    input  logic     refuse,
    input  logic     busy,
    output hold_st_e st
);
    hold_st_e st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            ST_OWN:   if (req_act && !refuse && !busy) st_nx = ST_REL;
            ST_REL:   st_nx = (!req_act || refuse) ? ST_RET : ST_GRANT;
            ST_GRANT: if (!req_act || (refuse && !busy)) st_nx = ST_RET;
            default:  st_nx = ST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= pin_req_n ? ST_OWN : ST_GRANT;
        else     st <= st_nx;
    end
endmodule

// File: rtl/bhc_oe_map.sv
module bhc_oe_map #(
    parameter int DATA_W    = 32,
    parameter int NUM_WE    = 2,
    parameter int NUM_ZONES = 3
) (
    input  logic                 drive,
    input  logic                 narrow,
    output logic                 addr_oe,
    output logic [DATA_W-1:0]    data_oe,
    output logic [NUM_WE-1:0]    we_oe,
    output logic                 rd_oe,
    output logic                 rw_oe,
    output logic [NUM_ZONES-1:0] zcs_oe
);
    localparam int HALF_W = DATA_W / 2;

    assign addr_oe = drive;
    assign rd_oe   = drive;
    assign rw_oe   = drive;

    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        if (i < HALF_W) begin : g_lo
            assign data_oe[i] = drive;
        end else begin : g_hi
            assign data_oe[i] = drive & ~narrow;
        end
    end

    for (genvar w = 0; w < NUM_WE; w++) begin : g_we
        assign we_oe[w] = drive;
    end

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zcs
        assign zcs_oe[z] = drive;
    end
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import bhc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WE    = 2,
    parameter int NUM_ZONES = 3,
    parameter int SYNC_N    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold_req_n,
    input  logic                 mode_wr_en,
    input  logic                 mode_wr_val,
    input  logic                 ext_busy,
    input  logic                 cpu_ext_req,
    input  logic                 narrow_mode,
    output logic                 hold_ack_n,
    output logic                 addr_oe,
    output logic [DATA_W-1:0]    data_oe,
    output logic [NUM_WE-1:0]    we_oe,
    output logic                 rd_oe,
    output logic                 rw_oe,
    output logic [NUM_ZONES-1:0] zcs_oe,
    output logic                 ext_stall
);
    logic     req_n_s;
    logic     refuse;
    hold_st_e st;
    bus_ctl_t ctl;

    bhc_sync #(.STAGES(SYNC_N)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (hold_req_n),
        .q   (req_n_s)
    );

    // Refusal bit, cleared by system reset
    always_ff @(posedge clk) begin
        if (rst)             refuse <= 1'b0;
        else if (mode_wr_en) refuse <= mode_wr_val;
    end

    bhc_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .pin_req_n (hold_req_n),
        .req_act   (~req_n_s),
        .refuse    (refuse),
        .busy      (ext_busy),
        .st        (st)
    );

    assign ctl        = ctl_of(st);
    assign hold_ack_n = ctl.ack_n;
    assign ext_stall  = cpu_ext_req & ~ctl.drive;

    bhc_oe_map #(
        .DATA_W    (DATA_W),
        .NUM_WE    (NUM_WE),
        .NUM_ZONES (NUM_ZONES)
    ) i_map (
        .drive   (ctl.drive),
        .narrow  (narrow_mode),
        .addr_oe (addr_oe),
        .data_oe (data_oe),
        .we_oe   (we_oe),
        .rd_oe   (rd_oe),
        .rw_oe   (rw_oe),
        .zcs_oe  (zcs_oe)
    );
endmodule

// File: rtl/bhc_chk.sv
module bhc_chk #(
    parameter int DATA_W    = 32,
    parameter int NUM_WE    = 2,
    parameter int NUM_ZONES = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ext_busy,
    input logic                 cpu_ext_req,
    input logic                 narrow_mode,
    input logic                 hold_ack_n,
    input logic                 addr_oe,
    input logic [DATA_W-1:0]    data_oe,
    input logic [NUM_WE-1:0]    we_oe,
    input logic                 rd_oe,
    input logic                 rw_oe,
    input logic [NUM_ZONES-1:0] zcs_oe
    ,input logic                ext_stall
);
    localparam int HALF_W = DATA_W / 2;

    // R9
    float_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> (!addr_oe && data_oe == '0 && we_oe == '0 && zcs_oe == '0 && !rd_oe && !rw_oe));

    // R9
    group_match_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_oe == addr_oe) && (rw_oe == addr_oe) && (we_oe == {NUM_WE{addr_oe}})
        && (zcs_oe == {NUM_ZONES{addr_oe}}) && (data_oe[HALF_W-1:0] == {HALF_W{addr_oe}}));

    // R9
    narrow_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
        narrow_mode |-> (data_oe[DATA_W-1:HALF_W] == '0));

    // R3
    ack_after_float_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> $past(!addr_oe));

    // R5
    drive_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe) |-> ($past(hold_ack_n) && hold_ack_n));

    // R4
    grant_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_oe) |-> !$past(ext_busy));

    // R8
    stall_exact_chk: assert property (@(posedge clk) disable iff (rst)
        ext_stall == (cpu_ext_req && !addr_oe));
endmodule

bind bus_hold_ctrl bhc_chk #(
    .DATA_W    (DATA_W),
    .NUM_WE    (NUM_WE),
    .NUM_ZONES (NUM_ZONES)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_busy    (ext_busy),
    .cpu_ext_req (cpu_ext_req),
    .narrow_mode (narrow_mode),
    .hold_ack_n  (hold_ack_n),
    .addr_oe     (addr_oe),
    .data_oe     (data_oe),
    .we_oe       (we_oe),
    .rd_oe       (rd_oe),
    .rw_oe       (rw_oe),
    .zcs_oe      (zcs_oe),
    .ext_stall   (ext_stall)
);

// File: tb/test_bus_hold_ctrl.sv
`timescale 1ns/1ps
module test_bus_hold_ctrl;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_req_n = 1'b1;
    logic          mode_wr_en = 1'b0;
    logic          mode_wr_val = 1'b0;
    logic          ext_busy = 1'b0;
    logic          cpu_ext_req = 1'b0;
    logic          narrow_mode = 1'b0;
    logic          hold_ack_n;
    logic          addr_oe;
    logic [DW-1:0] data_oe;
    logic [1:0]    we_oe;
    logic          rd_oe;
    logic          rw_oe;
    logic [2:0]    zcs_oe;
    logic          ext_stall;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bus_hold_ctrl i_bus_hold_ctrl (
        .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .mode_wr_en(mode_wr_en),
        .mode_wr_val(mode_wr_val), .ext_busy(ext_busy), .cpu_ext_req(cpu_ext_req),
        .narrow_mode(narrow_mode), .hold_ack_n(hold_ack_n), .addr_oe(addr_oe),
        .data_oe(data_oe), .we_oe(we_oe), .rd_oe(rd_oe), .rw_oe(rw_oe),
        .zcs_oe(zcs_oe), .ext_stall(ext_stall)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_data(bit drv, bit nar);
        logic [DW-1:0] lo_mask;
        lo_mask = (DW'(1) << (DW / 2)) - DW'(1);
        if (!drv) return '0;
        return nar ? lo_mask : ~DW'(0);
    endfunction

    // Compare the whole enable group and acknowledge against an expected drive level
    task automatic chk_bus(bit drv, bit ackn, string req);
        logic [63:0] got, want;
        got  = {hold_ack_n, addr_oe, rd_oe, rw_oe, we_oe, zcs_oe, data_oe};
        want = {ackn, drv, drv, drv, {2{drv}}, {3{drv}}, exp_data(drv, narrow_mode)};
        chk(got == want, req, got, want);
    endtask

    task automatic chk_stall(bit exp, string req);
        #1;
        chk(ext_stall == exp, req, 64'(ext_stall), 64'(exp));
    endtask

    task automatic write_refuse(bit v);
        mode_wr_en  = 1'b1;
        mode_wr_val = v;
        step();
        mode_wr_en  = 1'b0;
    endtask

    task automatic do_reset(bit req_low);
        hold_req_n = ~req_low;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int nar = 0; nar < 2; nar++) begin
            for (int d = 0; d < 4; d++) begin
                narrow_mode = nar[0];
                do_reset(1'b0 == 1'b1);
                step();
                chk_bus(1'b1, 1'b1, "R1 reset with request high");
                chk_stall(1'b0, "R8 no stall while driving");
                cpu_ext_req = 1'b1;
                chk_stall(1'b0, "R8 no stall while driving");
                cpu_ext_req = 1'b0;

                // grant, optionally held off by a busy bus
                ext_busy   = (d > 0);
                hold_req_n = 1'b0;
                step(2);
                chk_bus(1'b1, 1'b1, "R3 enables held through sync");
                if (d > 0) begin
                    step(d + 2);
                    chk_bus(1'b1, 1'b1, "R4 no grant while busy");
                    ext_busy = 1'b0;
                end
                step();
                chk_bus(1'b0, 1'b1, "R3 enables dropped");
                step();
                chk_bus(1'b0, 1'b0, "R3 acknowledge low");
                cpu_ext_req = 1'b1;
                chk_stall(1'b1, "R8 stall in grant");

                // release
                hold_req_n = 1'b1;
                step(2);
                chk_bus(1'b0, 1'b0, "R5 grant held through sync");
                step();
                chk_bus(1'b0, 1'b1, "R5 acknowledge high");
                chk_stall(1'b1, "R8 stall until drive returns");
                step();
                chk_bus(1'b1, 1'b1, "R5 drive restored");
                chk_stall(1'b0, "R8 stall drops with drive");
                cpu_ext_req = 1'b0;
            end

            // revoke by the refusal bit
            hold_req_n = 1'b0;
            step(4);
            chk_bus(1'b0, 1'b0, "R3 granted before revoke");
            write_refuse(1'b1);
            chk_bus(1'b0, 1'b0, "R6 grant until next edge");
            step();
            chk_bus(1'b0, 1'b1, "R6 acknowledge forced high");
            step();
            chk_bus(1'b1, 1'b1, "R6 drive back after revoke");
            step(5);
            chk_bus(1'b1, 1'b1, "R7 request ignored while refused");
            write_refuse(1'b0);
            step();
            chk_bus(1'b0, 1'b1, "R7 regrant enables drop");
            step();
            chk_bus(1'b0, 1'b0, "R7 regrant acknowledge");

            // revoke held off by busy
            ext_busy = 1'b1;
            write_refuse(1'b1);
            step(3);
            chk_bus(1'b0, 1'b0, "R6 grant kept while busy");
            ext_busy = 1'b0;
            step();
            chk_bus(1'b0, 1'b1, "R6 revoke after busy ends");
            step();
            chk_bus(1'b1, 1'b1, "R6 drive back");

            // reset clears the refusal bit
            hold_req_n = 1'b1;
            step();
            do_reset(1'b0);
            step();
            hold_req_n = 1'b0;
            step(3);
            chk_bus(1'b0, 1'b1, "R1 refusal cleared by reset");
            step();
            chk_bus(1'b0, 1'b0, "R1 grant after reset");
            hold_req_n = 1'b1;
            step(4);
            chk_bus(1'b1, 1'b1, "R5 released");

            // request low during reset
            do_reset(1'b1);
            step();
            chk_bus(1'b0, 1'b0, "R2 granted out of reset");
            cpu_ext_req = 1'b1;
            chk_stall(1'b1, "R8 stall after reset grant");
            hold_req_n = 1'b1;
            step(3);
            chk_bus(1'b0, 1'b1, "R2 release acknowledge");
            step();
            chk_bus(1'b1, 1'b1, "R2 release drive");
            chk_stall(1'b0, "R8 stall drops");
            cpu_ext_req = 1'b0;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule